// File: doc/BRIEF.md
# Monochrome LCD serial command sequencer

This block talks to a 128x64 monochrome LCD controller through a write-only serial link: a serial clock, a serial data line, an active-low chip select and a select line that marks each byte as a command or as display data. Right after reset it plays a fixed power-up script. The script contains several timed waits, counted in milliseconds from a clock-derived tick. The block then stays idle until a client asks it for work.

A client can ask for four things: refresh one 16-row band of the panel, set a new contrast level, put the panel to sleep, or wake it. A band refresh reads 256 bytes from an external band buffer that has a one-cycle read latency. It writes the first 128 bytes to controller page 2p and the second 128 bytes to page 2p+1. Within a run the next buffer byte is fetched while the current byte is still shifting out, so display data leaves the block with no gaps. While a script runs the block ignores all requests. A one-cycle pulse marks the end of every script, including the power-up script.

Top module: `mono_lcd_seq`

## Requirements
- R1: Each byte is sent most-significant bit first. The clock idles low. For each bit, the data line changes while the clock is low and stays steady while it is high. Each low phase and each high phase lasts SETUP_CYCLES clocks.
- R2: Chip select is low for every bit of every byte. The select line is 0 for command bytes and 1 for display-data bytes, and it does not change while the clock is high. Once chip select goes high, it stays high for at least GAP_CYCLES clocks.
- R3: During reset, chip select is high, the serial clock and the select line are low, and busy is high. After reset the block sends, in one chip-select window, the bytes 0xA2 0xA0 0xC8 0x40 0x2C 0x2E 0x2F 0x10 0xA6 0x81 0x1E 0xAF 0xA5 0xA4. It then pulses done once and drops busy.
- R4: In the power-up script, the gap before the next byte is at least 50 ms after each of 0x2C, 0x2E and 0x2F, at least 100 ms after 0xAF, and at least 200 ms after 0xA5. One millisecond is MS_CYCLES clocks.
- R5: After every command byte there is a pause of at least PAUSE_CYCLES clocks before the next bit. The bytes of a data run follow each other with no idle clock between them.
- R6: A refresh request (kind 0, band p on req_band) sends 0x10, 0x00, 0xB0|(2p), then buffer bytes 0 to 127 as data, and releases chip select. It then sends 0x10, 0x00, 0xB0|(2p+1), then buffer bytes 128 to 255, and releases chip select again.
- R7: A contrast request (kind 1) sends 0x81 followed by the level on req_level shifted right by two.
- R8: A sleep request (kind 2) sends 0xAC, 0xAE, 0xA5. A wake request (kind 3) sends 0xA4, 0xAF, then waits at least 50 ms before done.
- R9: A request made while busy is high is ignored: no byte is sent for it and no done pulse results. A request that is present in the cycle that done pulses is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 2 | 0 refresh, 1 contrast, 2 sleep, 3 wake |
| req_band | input | $clog2(PAGES/2) | Band index for a refresh |
| req_level | input | 8 | Contrast level before scaling |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse when a script ends |
| buf_addr | output | $clog2(2*COLS) | Band buffer read address |
| buf_data | input | 8 | Band buffer data, one cycle after the address |
| lcd_sclk | output | 1 | Serial clock |
| lcd_sdat | output | 1 | Serial data |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_a0 | output | 1 | 0 for command bytes, 1 for display data |

## Verification
Two things can happen in the same cycle: a running script finishes, and a new request arrives. The bench keeps a wake request asserted for the whole of a sleep script and releases it only after it has seen done. The result is judged by the serial byte log. It must hold exactly the sleep bytes followed by exactly one set of wake bytes, and there must be exactly two done pulses. This shows the request was neither lost nor duplicated. The bench also asserts requests during power-up and during a band refresh, and checks that the logs of those scripts contain no extra bytes.

// File: rtl/mlcd_pkg.sv
// Package: shared types and opcodes for the LCD command sequencer.
// Assumes the controller's command set described in the brief.
package mlcd_pkg;

    typedef enum logic [2:0] {
        SK_SEL   = 3'd0,  // assert chip select, command mode
        SK_CMD   = 3'd1,  // send one command byte
        SK_WAIT  = 3'd2,  // wait val milliseconds
        SK_DATA  = 3'd3,  // stream one half of the band buffer
        SK_DESEL = 3'd4,  // release chip select, hold the gap
        SK_END   = 3'd5   // script finished
    } step_kind_t;

    typedef struct packed {
        step_kind_t kind;
        logic [7:0] val;
    } step_t;

    typedef enum logic [2:0] {
        SC_INIT      = 3'd0,
        SC_BAND      = 3'd1,
        SC_CONTRAST  = 3'd2,
        SC_SLEEP_ON  = 3'd3,
        SC_SLEEP_OFF = 3'd4
    } script_t;

    localparam logic [1:0] REQ_REFRESH   = 2'd0;
    localparam logic [1:0] REQ_CONTRAST  = 2'd1;
    localparam logic [1:0] REQ_SLEEP_ON  = 2'd2;
    localparam logic [1:0] REQ_SLEEP_OFF = 2'd3;

    localparam logic [7:0] OP_BIAS9      = 8'hA2;
    localparam logic [7:0] OP_SEG_NORM   = 8'hA0;
    localparam logic [7:0] OP_COM_REV    = 8'hC8;
    localparam logic [7:0] OP_LINE0      = 8'h40;
    localparam logic [7:0] OP_PWR_BOOST  = 8'h2C;
    localparam logic [7:0] OP_PWR_REG    = 8'h2E;
    localparam logic [7:0] OP_PWR_ALL    = 8'h2F;
    localparam logic [7:0] OP_RATIO0     = 8'h10;
    localparam logic [7:0] OP_POS_IMAGE  = 8'hA6;
    localparam logic [7:0] OP_VOLUME     = 8'h81;
    localparam logic [7:0] INIT_VOLUME   = 8'h1E;
    localparam logic [7:0] OP_DISP_ON    = 8'hAF;
    localparam logic [7:0] OP_DISP_OFF   = 8'hAE;
    localparam logic [7:0] OP_FORCE_ALL  = 8'hA5;
    localparam logic [7:0] OP_FORCE_NONE = 8'hA4;
    localparam logic [7:0] OP_INDIC_OFF  = 8'hAC;
    localparam logic [7:0] OP_COL_HI     = 8'h10;  // column 0, high nibble
    localparam logic [7:0] OP_COL_LO     = 8'h00;  // column 0, low nibble
    localparam logic [7:0] OP_PAGE       = 8'hB0;

endpackage

// File: rtl/mlcd_timer.sv
// Module: loadable down-counter used for pauses, gaps and millisecond waits.
// Assumes: a load sets the count, and zero is reported once it reaches 0.
module mlcd_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Purpose: load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/mlcd_shifter.sv
// Module: serialises one byte MSB first onto the serial clock and data lines.
// Assumes: start is taken only when ready; ready also holds in the final
// phase of a byte, so the next byte can follow with no idle cycle.
module mlcd_shifter #(
    parameter int SETUP_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    output logic       ready,
    output logic       last,
    output logic       sclk,
    output logic       sdat
);
    localparam int SW = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1;

    logic          active;
    logic          hi;
    logic [2:0]    bitn;
    logic [SW-1:0] cnt;
    logic [7:0]    sr;
    logic          phase_end;

    assign phase_end = (cnt == SW'(SETUP_CYCLES - 1));
    assign last      = active && hi && phase_end && (bitn == 3'd7);
    assign ready     = !active || last;

    // Purpose: step through low/high phases of the eight bits of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hi     <= 1'b0;
            bitn   <= '0;
            cnt    <= '0;
            sr     <= '0;
        end else if (start && ready) begin
            active <= 1'b1;
            hi     <= 1'b0;
            bitn   <= '0;
            cnt    <= '0;
            sr     <= din;
        end else if (active) begin
            if (!phase_end) begin
                cnt <= cnt + SW'(1);
            end else begin
                cnt <= '0;
                if (!hi) begin
                    hi <= 1'b1;
                end else begin
                    hi <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sr   <= {sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sclk = active && hi;
    assign sdat = sr[7];
endmodule

// File: rtl/mlcd_script.sv
// Module: combinational store of the five command scripts, indexed by step.
// Assumes: every script starts with a select step and ends with an end step.
module mlcd_script
    import mlcd_pkg::*;
#(
    parameter int BW = 2
) (
    input  script_t       script,
    input  logic [4:0]    pc,
    input  logic [BW-1:0] band,
    input  logic [7:0]    level,
    output step_t         step
);
    logic [7:0] page_even;
    logic [7:0] page_odd;
    logic [7:0] vol_byte;
    logic       unused_lvl;

    assign page_even  = OP_PAGE | 8'({band, 1'b0});
    assign page_odd   = OP_PAGE | 8'({band, 1'b1});
    assign vol_byte   = {2'b00, level[7:2]};
    assign unused_lvl = ^level[1:0];

    function automatic step_t mk(input step_kind_t k, input logic [7:0] v);
        step_t s;
        s.kind = k;
        s.val  = v;
        return s;
    endfunction

    // Purpose: look up the step at index pc of the selected script.
    always_comb begin
        step = mk(SK_END, 8'h00);
        unique case (script)
            SC_INIT: begin
                case (pc)
                    5'd0:  step = mk(SK_SEL,   8'h00);
                    5'd1:  step = mk(SK_CMD,   OP_BIAS9);
                    5'd2:  step = mk(SK_CMD,   OP_SEG_NORM);
                    5'd3:  step = mk(SK_CMD,   OP_COM_REV);
                    5'd4:  step = mk(SK_CMD,   OP_LINE0);
                    5'd5:  step = mk(SK_CMD,   OP_PWR_BOOST);
                    5'd6:  step = mk(SK_WAIT,  8'd50);
                    5'd7:  step = mk(SK_CMD,   OP_PWR_REG);
                    5'd8:  step = mk(SK_WAIT,  8'd50);
                    5'd9:  step = mk(SK_CMD,   OP_PWR_ALL);
                    5'd10: step = mk(SK_WAIT,  8'd50);
                    5'd11: step = mk(SK_CMD,   OP_RATIO0);
                    5'd12: step = mk(SK_CMD,   OP_POS_IMAGE);
                    5'd13: step = mk(SK_CMD,   OP_VOLUME);
                    5'd14: step = mk(SK_CMD,   INIT_VOLUME);
                    5'd15: step = mk(SK_CMD,   OP_DISP_ON);
                    5'd16: step = mk(SK_WAIT,  8'd100);
                    5'd17: step = mk(SK_CMD,   OP_FORCE_ALL);
                    5'd18: step = mk(SK_WAIT,  8'd200);
                    5'd19: step = mk(SK_CMD,   OP_FORCE_NONE);
                    5'd20: step = mk(SK_DESEL, 8'h00);
                    default: step = mk(SK_END, 8'h00);
                endcase
            end
            SC_BAND: begin
                case (pc)
                    5'd0:  step = mk(SK_SEL,   8'h00);
                    5'd1:  step = mk(SK_CMD,   OP_COL_HI);
                    5'd2:  step = mk(SK_CMD,   OP_COL_LO);
                    5'd3:  step = mk(SK_CMD,   page_even);
                    5'd4:  step = mk(SK_DATA,  8'h00);
                    5'd5:  step = mk(SK_DESEL, 8'h00);
                    5'd6:  step = mk(SK_SEL,   8'h00);
                    5'd7:  step = mk(SK_CMD,   OP_COL_HI);
                    5'd8:  step = mk(SK_CMD,   OP_COL_LO);
                    5'd9:  step = mk(SK_CMD,   page_odd);
                    5'd10: step = mk(SK_DATA,  8'h01);
                    5'd11: step = mk(SK_DESEL, 8'h00);
                    default: step = mk(SK_END, 8'h00);
                endcase
            end
            SC_CONTRAST: begin
                case (pc)
                    5'd0:  step = mk(SK_SEL,   8'h00);
                    5'd1:  step = mk(SK_CMD,   OP_VOLUME);
                    5'd2:  step = mk(SK_CMD,   vol_byte);
                    5'd3:  step = mk(SK_DESEL, 8'h00);
                    default: step = mk(SK_END, 8'h00);
                endcase
            end
            SC_SLEEP_ON: begin
                case (pc)
                    5'd0:  step = mk(SK_SEL,   8'h00);
                    5'd1:  step = mk(SK_CMD,   OP_INDIC_OFF);
                    5'd2:  step = mk(SK_CMD,   OP_DISP_OFF);
                    5'd3:  step = mk(SK_CMD,   OP_FORCE_ALL);
                    5'd4:  step = mk(SK_DESEL, 8'h00);
                    default: step = mk(SK_END, 8'h00);
                endcase
            end
            SC_SLEEP_OFF: begin
                case (pc)
                    5'd0:  step = mk(SK_SEL,   8'h00);
                    5'd1:  step = mk(SK_CMD,   OP_FORCE_NONE);
                    5'd2:  step = mk(SK_CMD,   OP_DISP_ON);
                    5'd3:  step = mk(SK_WAIT,  8'd50);
                    5'd4:  step = mk(SK_DESEL, 8'h00);
                    default: step = mk(SK_END, 8'h00);
                endcase
            end
            default: step = mk(SK_END, 8'h00);
        endcase
    end
endmodule

// File: rtl/mono_lcd_seq.sv
// Module: top of the LCD command sequencer. Runs the power-up script after
// reset, then accepts refresh, contrast, sleep and wake requests one at a time.
// Assumes: the band buffer returns data one cycle after the address.
module mono_lcd_seq
    import mlcd_pkg::*;
#(
    parameter int COLS         = 128,
    parameter int PAGES        = 8,
    parameter int MS_CYCLES    = 50000,
    parameter int PAUSE_CYCLES = 500,
    parameter int SETUP_CYCLES = 2,
    parameter int GAP_CYCLES   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [1:0]                        req_kind,
    input  logic [$clog2(PAGES/2)-1:0]        req_band,
    input  logic [7:0]                        req_level,
    output logic                              busy,
    output logic                              done,
    output logic [$clog2(2*COLS)-1:0]         buf_addr,
    input  logic [7:0]                        buf_data,
    output logic                              lcd_sclk,
    output logic                              lcd_sdat,
    output logic                              lcd_cs_n,
    output logic                              lcd_a0
);
    localparam int BW = $clog2(PAGES / 2);
    localparam int AW = $clog2(2 * COLS);
    localparam int CW = $clog2(COLS + 1);

    typedef enum logic [2:0] {
        ST_STEP  = 3'd0,
        ST_CMDW  = 3'd1,
        ST_TIME  = 3'd2,
        ST_PRIME = 3'd3,
        ST_DATA  = 3'd4,
        ST_IDLE  = 3'd5
    } state_t;

    state_t        st;
    script_t       script;
    logic [4:0]    pc;
    logic [BW-1:0] band_q;
    logic [7:0]    level_q;
    logic          cs_n_q;
    logic          a0_q;
    logic          done_q;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] sent;
    step_t         step;

    logic          sh_start;
    logic [7:0]    sh_din;
    logic          sh_ready;
    logic          sh_last;
    logic          tmr_load;
    logic [31:0]   tmr_val;
    logic          tmr_zero;
    logic          run_full;

    mlcd_script #(.BW(BW)) u_script (
        .script (script),
        .pc     (pc),
        .band   (band_q),
        .level  (level_q),
        .step   (step)
    );

    mlcd_shifter #(.SETUP_CYCLES(SETUP_CYCLES)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .din    (sh_din),
        .ready  (sh_ready),
        .last   (sh_last),
        .sclk   (lcd_sclk),
        .sdat   (lcd_sdat)
    );

    mlcd_timer #(.W(32)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign run_full = (sent == CW'(COLS));

    // Purpose: start bytes and load the timer according to the current state.
    always_comb begin
        sh_start = 1'b0;
        sh_din   = step.val;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            ST_STEP: begin
                case (step.kind)
                    SK_CMD:   sh_start = 1'b1;
                    SK_WAIT: begin
                        tmr_load = 1'b1;
                        tmr_val  = 32'(step.val) * 32'(MS_CYCLES);
                    end
                    SK_DESEL: begin
                        tmr_load = 1'b1;
                        tmr_val  = 32'(GAP_CYCLES);
                    end
                    default: ;
                endcase
            end
            ST_CMDW: begin
                if (sh_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = 32'(PAUSE_CYCLES);
                end
            end
            ST_DATA: begin
                sh_din = buf_data;
                if (sh_ready && !run_full) sh_start = 1'b1;
                if (run_full && sh_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = 32'(PAUSE_CYCLES);
                end
            end
            default: ;
        endcase
    end

    // Purpose: walk the script steps and hold the link control lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_STEP;
            script  <= SC_INIT;
            pc      <= '0;
            band_q  <= '0;
            level_q <= '0;
            cs_n_q  <= 1'b1;
            a0_q    <= 1'b0;
            done_q  <= 1'b0;
            rd_addr <= '0;
            sent    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        case (req_kind)
                            REQ_REFRESH:  script <= SC_BAND;
                            REQ_CONTRAST: script <= SC_CONTRAST;
                            REQ_SLEEP_ON: script <= SC_SLEEP_ON;
                            default:      script <= SC_SLEEP_OFF;
                        endcase
                        band_q  <= req_band;
                        level_q <= req_level;
                        pc      <= '0;
                        st      <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    case (step.kind)
                        SK_SEL: begin
                            cs_n_q <= 1'b0;
                            a0_q   <= 1'b0;
                            pc     <= pc + 5'd1;
                        end
                        SK_CMD:   st <= ST_CMDW;
                        SK_WAIT:  st <= ST_TIME;
                        SK_DATA: begin
                            a0_q    <= 1'b1;
                            rd_addr <= step.val[0] ? AW'(COLS) : '0;
                            sent    <= '0;
                            st      <= ST_PRIME;
                        end
                        SK_DESEL: begin
                            cs_n_q <= 1'b1;
                            st     <= ST_TIME;
                        end
                        default: begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end
                    endcase
                end
                ST_CMDW: begin
                    if (sh_last) st <= ST_TIME;
                end
                ST_TIME: begin
                    if (tmr_zero) begin
                        pc <= pc + 5'd1;
                        st <= ST_STEP;
                    end
                end
                ST_PRIME: st <= ST_DATA;
                ST_DATA: begin
                    if (sh_start) begin
                        rd_addr <= rd_addr + AW'(1);
                        sent    <= sent + CW'(1);
                    end
                    if (run_full && sh_last) st <= ST_TIME;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign buf_addr = rd_addr;
    assign lcd_cs_n = cs_n_q;
    assign lcd_a0   = a0_q;
endmodule

// File: rtl/mono_lcd_seq_chk.sv
// Module: protocol checker for the LCD sequencer's serial link and handshake.
// Assumes: bound into every instance of mono_lcd_seq.
module mono_lcd_seq_chk #(
    parameter int GAP_CYCLES = 10
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic lcd_sclk,
    input logic lcd_sdat,
    input logic lcd_cs_n,
    input logic lcd_a0
);
    logic [15:0] high_cnt;

    // Purpose: count cycles chip select has stayed high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                high_cnt <= 16'(GAP_CYCLES);
        else if (!lcd_cs_n)        high_cnt <= '0;
        else if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 16'd1;
    end

    a_r2_cs_low_when_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sclk |-> !lcd_cs_n);

    a_r1_data_steady_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_sdat));

    a_r2_mode_steady_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_a0));

    a_r2_release_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> !lcd_sclk);

    a_r2_gap_before_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_cs_n) |-> (32'(high_cnt) >= 32'(GAP_CYCLES)));

    a_r9_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mono_lcd_seq mono_lcd_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .lcd_sclk (lcd_sclk),
    .lcd_sdat (lcd_sdat),
    .lcd_cs_n (lcd_cs_n),
    .lcd_a0   (lcd_a0)
);

// File: tb/mono_lcd_seq_test.sv
// Bench: decodes the serial link into a byte log and checks it against the
// requirements. Contrast cases come from a vector table; the rest are directed.
module mono_lcd_seq_test;
    localparam int COLS  = 128;
    localparam int PAGES = 8;
    localparam int MS    = 20;
    localparam int PAUSE = 3;
    localparam int SETUP = 1;
    localparam int GAP   = 2;
    localparam int WD_LIMIT = 150000;
    localparam int LOGN  = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_band = 2'd0;
    logic [7:0] req_level = 8'd0;
    logic       busy, done;
    logic [7:0] buf_addr;
    logic [7:0] buf_data;
    logic       lcd_sclk, lcd_sdat, lcd_cs_n, lcd_a0;

    mono_lcd_seq #(
        .COLS(COLS), .PAGES(PAGES), .MS_CYCLES(MS),
        .PAUSE_CYCLES(PAUSE), .SETUP_CYCLES(SETUP), .GAP_CYCLES(GAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_band(req_band), .req_level(req_level), .busy(busy), .done(done),
        .buf_addr(buf_addr), .buf_data(buf_data), .lcd_sclk(lcd_sclk),
        .lcd_sdat(lcd_sdat), .lcd_cs_n(lcd_cs_n), .lcd_a0(lcd_a0)
    );

    always #10 clk = ~clk;  // 50 MHz

    // band buffer model with one-cycle read latency
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    always @(posedge clk) buf_data <= mem[buf_addr];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // serial monitor
    logic [7:0] log_b  [LOGN];
    logic       log_a0 [LOGN];
    int         log_tf [LOGN];
    int         log_tl [LOGN];
    int  n_log = 0;
    int  bitc = 0;
    int  cur_t0 = 0;
    logic cur_a0 = 1'b0;
    logic [7:0] cur_byte = 8'd0;
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;
    int  cs_rises = 0;
    int  cs_bad = 0;
    int  done_cnt = 0;
    int  done_t = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (lcd_cs_n && !prev_cs) cs_rises = cs_rises + 1;
            if (done) begin done_cnt = done_cnt + 1; done_t = cyc; end
            if (lcd_sclk && !prev_sclk) begin
                if (bitc == 0) begin cur_t0 = cyc; cur_a0 = lcd_a0; end
                cur_byte = {cur_byte[6:0], lcd_sdat};
                if (lcd_cs_n) cs_bad = cs_bad + 1;
                bitc = bitc + 1;
                if (bitc == 8) begin
                    if (n_log < LOGN) begin
                        log_b[n_log]  = cur_byte;
                        log_a0[n_log] = cur_a0;
                        log_tf[n_log] = cur_t0;
                        log_tl[n_log] = cyc;
                    end
                    n_log = n_log + 1;
                    bitc = 0;
                end
            end
        end
        prev_sclk = lcd_sclk;
        prev_cs   = lcd_cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic request(input logic [1:0] k, input logic [1:0] b, input logic [7:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_band = b; req_level = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // contrast vectors: {level, expected second byte}
    localparam logic [15:0] CTAB [4] = '{16'hFF3F, 16'h781E, 16'h0300, 16'h8020};
    localparam logic [7:0]  INIT_EXP [14] = '{8'hA2, 8'hA0, 8'hC8, 8'h40, 8'h2C, 8'h2E,
        8'h2F, 8'h10, 8'hA6, 8'h81, 8'h1E, 8'hAF, 8'hA5, 8'hA4};

    // check one full band refresh starting at log index base
    task automatic check_band(input int b, input int base, input int cs0);
        chk(n_log - base == 262, "R6 band byte count", n_log - base, 262);
        chk(cs_rises - cs0 == 2, "R6 two select windows", cs_rises - cs0, 2);
        for (int h = 0; h < 2; h++) begin
            int o = base + h * 131;
            int bad = 0;
            int gapbad = 0;
            chk(log_b[o] == 8'h10 && log_b[o+1] == 8'h00, "R6 column zero",
                {log_b[o], log_b[o+1]}, 16'h1000);
            chk(log_b[o+2] == 8'(8'hB0 | (2 * b + h)), "R6 page index", log_b[o+2], 8'hB0 | (2 * b + h));
            chk(!log_a0[o] && !log_a0[o+1] && !log_a0[o+2], "R2 command mode",
                {log_a0[o], log_a0[o+1], log_a0[o+2]}, 0);
            for (int k = 0; k < COLS; k++) begin
                if (log_b[o+3+k] !== mem[h * COLS + k] || log_a0[o+3+k] !== 1'b1) bad++;
                if (k > 0 && (log_tf[o+3+k] - log_tl[o+2+k]) != 2 * SETUP) gapbad++;
            end
            chk(bad == 0, "R6 data bytes and R2 data mode", bad, 0);
            chk(gapbad == 0, "R5 back-to-back data", gapbad, 0);
        end
    endtask

    initial begin
        int base;
        int cs0;
        int d0;
        int bad;
        repeat (4) @(negedge clk);
        // R3 reset state
        chk(lcd_cs_n == 1'b1 && lcd_sclk == 1'b0 && lcd_a0 == 1'b0, "R3 reset outputs",
            {lcd_cs_n, lcd_sclk, lcd_a0}, 3'b100);
        chk(busy == 1'b1 && done == 1'b0, "R3 reset busy", {busy, done}, 2'b10);
        rst_n = 1'b1;

        // R9: requests held during power-up are ignored
        req_valid = 1'b1; req_kind = 2'd1; req_level = 8'hFF;
        repeat (300) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(n_log == 14, "R9 no extra bytes after power-up", n_log, 14);
        chk(done_cnt == 1, "R3 single done after power-up", done_cnt, 1);
        chk(busy == 1'b0, "R3 idle after power-up", busy, 0);
        bad = 0;
        for (int i = 0; i < 14; i++) if (log_b[i] !== INIT_EXP[i] || log_a0[i] !== 1'b0) bad++;
        chk(bad == 0, "R3 power-up bytes", bad, 0);
        chk(log_b[0] == 8'hA2 && log_b[13] == 8'hA4, "R1 MSB-first framing", {log_b[0], log_b[13]}, 16'hA2A4);
        chk(cs_rises == 1 && cs_bad == 0, "R2 one select window", cs_rises, 1);
        // R4 waits
        for (int i = 4; i < 7; i++) begin
            d0 = log_tf[i+1] - log_tl[i];
            chk(d0 >= 50 * MS && d0 < 50 * MS + 40, "R4 50 ms wait", d0, 50 * MS);
        end
        d0 = log_tf[12] - log_tl[11];
        chk(d0 >= 100 * MS && d0 < 100 * MS + 40, "R4 100 ms wait", d0, 100 * MS);
        d0 = log_tf[13] - log_tl[12];
        chk(d0 >= 200 * MS && d0 < 200 * MS + 40, "R4 200 ms wait", d0, 200 * MS);
        d0 = log_tf[1] - log_tl[0];
        chk(d0 >= PAUSE + 2 * SETUP, "R5 command pause", d0, PAUSE + 2 * SETUP);

        // R7 contrast vectors
        for (int v = 0; v < 4; v++) begin
            base = n_log;
            request(2'd1, 2'd0, CTAB[v][15:8]);
            wait_done();
            repeat (5) @(negedge clk);
            chk(n_log - base == 2, "R7 contrast byte count", n_log - base, 2);
            chk(log_b[base] == 8'h81 && log_b[base+1] == CTAB[v][7:0], "R7 contrast bytes",
                {log_b[base], log_b[base+1]}, {8'h81, CTAB[v][7:0]});
            chk(!log_a0[base] && !log_a0[base+1], "R2 contrast in command mode",
                {log_a0[base], log_a0[base+1]}, 0);
        end

        // R6 band refresh, first and last band
        for (int bb = 0; bb < 4; bb += 3) begin
            base = n_log; cs0 = cs_rises;
            request(2'd0, 2'(bb), 8'd0);
            wait_done();
            repeat (10) @(negedge clk);
            check_band(bb, base, cs0);
        end

        // R9: request during a band refresh is ignored
        base = n_log; cs0 = cs_rises; d0 = done_cnt;
        request(2'd0, 2'd1, 8'd0);
        repeat (60) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (200) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9 no done for refused request", done_cnt - d0, 1);
        check_band(1, base, cs0);

        // R8 and R9: wake request held across the end of a sleep script
        base = n_log; d0 = done_cnt;
        request(2'd2, 2'd0, 8'd0);
        req_valid = 1'b1; req_kind = 2'd3;
        while (!done) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(n_log - base == 5, "R9 sleep then one wake", n_log - base, 5);
        chk(done_cnt - d0 == 2, "R9 two done pulses", done_cnt - d0, 2);
        chk(log_b[base] == 8'hAC && log_b[base+1] == 8'hAE && log_b[base+2] == 8'hA5,
            "R8 sleep bytes", {log_b[base], log_b[base+1], log_b[base+2]}, 24'hACAEA5);
        chk(log_b[base+3] == 8'hA4 && log_b[base+4] == 8'hAF, "R8 wake bytes",
            {log_b[base+3], log_b[base+4]}, 16'hA4AF);
        chk(done_t - log_tl[base+4] >= 50 * MS, "R8 wake wait", done_t - log_tl[base+4], 50 * MS);
        chk(cs_bad == 0, "R2 select held for all bits", cs_bad, 0);

        summary();
        $finish;
    end
endmodule